// File: doc/BRIEF.md
# Programmable-Wait Memory Read Sequencer

This block runs read cycles on one bank of static memory, ROM or I/O. The CPU side raises a request with an address, a 14-bit bank setup word and two mode bits. At that edge the block latches all of them. It then drives the address, chip select, output enable and lane enables on the device pins. It paces the access with a programmed number of wait cycles. It can also extend the access until the device raises its Ready line.

The end of an access depends on the mode. With Ready polling off, the access ends when the wait count runs out. With polling on, the block waits for Ready. It can take Ready directly, or through a two-flop synchronizer when the device runs on its own clock. After the data is captured, chip select and output enable drop for a programmable number of hold cycles, while the address stays on the pins. A single-cycle acknowledge returns the data to the CPU. If the device never answers, a 128-cycle watchdog ends the access with an error acknowledge, unless the CPU has switched that watchdog off.

Top module: `membus_rd_ctrl`

## Requirements
- R1: The setup word `cpu_cfg` is split into fields from the top bit down: lane mode [13:12], Ready polling enable [11], wait count [10:5], chip-select delay [4], output-enable delay [3] and hold count [2:0]. The word, the address and the two mode bits are latched only when a request is accepted. Changes to any of them during an access have no effect.
- R2: The cycle after acceptance is access cycle 1. Chip select is high from cycle 1 + csdelay through the last access cycle, and low at all other times.
- R3: Output enable is high from cycle 1 + csdelay + oedelay through the last access cycle. It is never high without chip select.
- R4: If the wait count W is 0, or Ready polling is off, Ready is ignored. Cycle 1 + W is the last access cycle, and the data input is captured at the clock edge that ends it.
- R5: If polling is on and W ≥ 1, Ready is examined at the end of every cycle from cycle 1 + W onward. With direct Ready, the cycle after the first high sample is the last access cycle, and data is captured at its end.
- R6: When `cpu_async_rdy` is 1, Ready passes through two flops before it is examined. A Ready first driven in cycle r therefore counts as seen in cycle r + 2.
- R7: If polling has seen no Ready by the end of cycle 128, and `cpu_tmo_dis` is 0, the access ends. Cycle 129 carries `cpu_ack` and `cpu_err` together, with chip select and output enable low.
- R8: When `cpu_tmo_dis` is 1, polling continues past cycle 128 with no error.
- R9: After a capture, the hold phase lasts H cycles for a hold count H from 1 to 7, and 1 cycle for H = 0. During hold, chip select and output enable are low, while the address and lane enables keep their values.
- R10: `cpu_ack` is high for exactly one cycle, the first hold cycle. In that cycle `cpu_rdata` shows the captured data and `cpu_err` is 0.
- R11: A request is accepted only while the block is idle. A request held high through an access starts nothing, and the address pins stay stable.
- R12: The lane enables are 1111 in word mode (lane code 1x). In halfword mode (code 01) they are {1,1,a1,a0}, and in byte mode (code 00) they are {1,0,a1,a0}, where a1 and a0 are the two low address bits. They are 0000 while idle.
- R13: After reset the block is idle, with chip select, output enable, lane enables, acknowledge and error all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Read request, sampled while idle |
| cpu_addr | input | AW | Read address |
| cpu_cfg | input | 14 | Bank setup word |
| cpu_async_rdy | input | 1 | 1: Ready is synchronized before use |
| cpu_tmo_dis | input | 1 | 1: disables the 128-cycle watchdog |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_err | output | 1 | Timeout flag, valid with cpu_ack |
| cpu_rdata | output | DW | Captured read data |
| mem_addr | output | AW | Device address |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_be | output | 4 | Lane enables, with low address bits in narrow modes |
| mem_rdy | input | 1 | Device Ready |
| mem_din | input | DW | Device read data |

## Verification
The assertions assume that every setup word is legal, meaning the wait count is at least csdelay + oedelay. They also assume that the CPU leaves the address, the setup word and the mode bits alone at the accepting edge. The stimulus builds every setup word from values that satisfy that bound. It drives all inputs half a cycle away from the active edge. It clears Ready between accesses so that the synchronizer starts empty. The only input changes made during an access come from the deliberate held-request case, and only after acceptance.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;

  localparam int CFG_W = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WAIT, ST_POLL, ST_CAPT, ST_HOLD, ST_ERR
  } rdc_state_e;

  typedef struct packed {
    logic [1:0] lane_mode;
    logic       rdy_en;
    logic [5:0] wait_n;
    logic       cs_dly;
    logic       oe_dly;
    logic [2:0] hold_n;
  } rdc_cfg_t;

  localparam logic [1:0] LM_BYTE = 2'b00;
  localparam logic [1:0] LM_HALF = 2'b01;

  // number of hold cycles: a zero count still gives one
  function automatic logic [3:0] hold_len(input logic [2:0] h);
    return (h == 3'd0) ? 4'd1 : {1'b0, h};
  endfunction

  // Ready is examined only with polling enabled and a nonzero wait count
  function automatic logic polls_ready(input rdc_cfg_t c);
    return c.rdy_en && (c.wait_n != 6'd0);
  endfunction

  // first access cycle in which a strobe is driven
  function automatic logic [2:0] strobe_start(input logic d0, input logic d1);
    return 3'd1 + {2'b00, d0} + {2'b00, d1};
  endfunction

  function automatic logic [3:0] lane_enables(input logic [1:0] mode,
                                              input logic [1:0] alow);
    if (mode[1])              return 4'b1111;
    else if (mode == LM_HALF) return {2'b11, alow};
    else                      return {2'b10, alow};
  endfunction

endpackage

// File: rtl/rdc_rdy_sync.sv
`timescale 1ns/1ps
module rdc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_raw,
  input  logic use_sync,
  output logic rdy_eff
);

  logic [STAGES-1:0] flop;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop[0] <= 1'b0;
        else        flop[0] <= rdy_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop[i] <= 1'b0;
        else        flop[i] <= flop[i-1];
      end
    end
  end

  assign rdy_eff = use_sync ? flop[STAGES-1] : rdy_raw;

endmodule

// File: rtl/rdc_seq.sv
`timescale 1ns/1ps
module rdc_seq import rdc_pkg::*; #(
  parameter int CW  = 8,
  parameter int TMO = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  rdc_cfg_t       cfg,
  input  logic           tmo_dis,
  input  logic           rdy_eff,
  output rdc_state_e     st,
  output logic [CW-1:0]  cyc,
  output logic           cap_evt,
  output logic           tmo_evt
);

  localparam logic [CW-1:0] CYC_MAX = '1;
  localparam logic [CW-1:0] TMO_C   = CW'(TMO);

  rdc_state_e    nxt;
  logic [2:0]    hcnt;
  logic          poll;
  logic [CW-1:0] wait_c;
  logic [CW-1:0] wait_end;

  assign poll     = polls_ready(cfg);
  assign wait_c   = CW'(cfg.wait_n);
  assign wait_end = wait_c + CW'(1);

  always_comb begin
    nxt     = st;
    cap_evt = 1'b0;
    tmo_evt = 1'b0;
    unique case (st)
      ST_IDLE: if (start) nxt = ST_ADDR;
      ST_ADDR: begin
        if (cfg.wait_n == 6'd0) begin
          cap_evt = 1'b1;
          nxt     = ST_HOLD;
        end else if (poll && cfg.wait_n == 6'd1) begin
          nxt = ST_POLL;
        end else begin
          nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!poll && cyc == wait_end) begin
          cap_evt = 1'b1;
          nxt     = ST_HOLD;
        end else if (poll && cyc == wait_c) begin
          nxt = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rdy_eff) begin
          nxt = ST_CAPT;
        end else if (!tmo_dis && cyc >= TMO_C) begin
          tmo_evt = 1'b1;
          nxt     = ST_ERR;
        end
      end
      ST_CAPT: begin
        cap_evt = 1'b1;
        nxt     = ST_HOLD;
      end
      ST_HOLD: if (hcnt == 3'd0) nxt = ST_IDLE;
      ST_ERR:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cyc  <= '0;
      hcnt <= '0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE)       cyc <= start ? CW'(1) : '0;
      else if (cyc != CYC_MAX) cyc <= cyc + CW'(1);
      if (cap_evt)                          hcnt <= 3'(hold_len(cfg.hold_n) - 4'd1);
      else if (st == ST_HOLD && hcnt != 0)  hcnt <= hcnt - 3'd1;
    end
  end

endmodule

// File: rtl/rdc_pins.sv
`timescale 1ns/1ps
module rdc_pins import rdc_pkg::*; #(
  parameter int CW = 8
) (
  input  rdc_state_e    st,
  input  logic [CW-1:0] cyc,
  input  rdc_cfg_t      cfg,
  input  logic [1:0]    alow,
  output logic          cs,
  output logic          oe,
  output logic [3:0]    be
);

  logic          acc;
  logic [CW-1:0] cs_first;
  logic [CW-1:0] oe_first;

  assign acc      = st inside {ST_ADDR, ST_WAIT, ST_POLL, ST_CAPT};
  assign cs_first = CW'(strobe_start(cfg.cs_dly, 1'b0));
  assign oe_first = CW'(strobe_start(cfg.cs_dly, cfg.oe_dly));
  assign cs       = acc && (cyc >= cs_first);
  assign oe       = acc && (cyc >= oe_first);
  assign be       = (st == ST_IDLE) ? 4'b0000 : lane_enables(cfg.lane_mode, alow);

endmodule

// File: rtl/membus_rd_ctrl.sv
`timescale 1ns/1ps
module membus_rd_ctrl import rdc_pkg::*; #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int TMO         = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [CFG_W-1:0] cpu_cfg,
  input  logic             cpu_async_rdy,
  input  logic             cpu_tmo_dis,
  output logic             cpu_ack,
  output logic             cpu_err,
  output logic [DW-1:0]    cpu_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs,
  output logic             mem_oe,
  output logic [3:0]       mem_be,
  input  logic             mem_rdy,
  input  logic [DW-1:0]    mem_din
);

  localparam int CW = $clog2(((TMO > 64) ? TMO : 64) + 2);

  rdc_cfg_t      cfg_q;
  logic [AW-1:0] addr_q;
  logic          async_q;
  logic          tdis_q;
  logic [DW-1:0] rdata_q;
  logic          ack_q;
  logic          err_q;

  rdc_state_e    st;
  logic [CW-1:0] cyc;
  logic          cap_evt;
  logic          tmo_evt;
  logic          rdy_eff;

  // named events for the checker
  logic busy;
  logic start;
  logic in_poll;
  logic in_hold;

  assign busy    = (st != ST_IDLE);
  assign start   = cpu_req && !busy;
  assign in_poll = (st == ST_POLL);
  assign in_hold = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      async_q <= 1'b0;
      tdis_q  <= 1'b0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start) begin
        cfg_q   <= rdc_cfg_t'(cpu_cfg);
        addr_q  <= cpu_addr;
        async_q <= cpu_async_rdy;
        tdis_q  <= cpu_tmo_dis;
      end
      if (cap_evt) rdata_q <= mem_din;
      ack_q <= cap_evt || tmo_evt;
      err_q <= tmo_evt;
    end
  end

  rdc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_raw  (mem_rdy),
    .use_sync (async_q),
    .rdy_eff  (rdy_eff)
  );

  rdc_seq #(.CW(CW), .TMO(TMO)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg     (cfg_q),
    .tmo_dis (tdis_q),
    .rdy_eff (rdy_eff),
    .st      (st),
    .cyc     (cyc),
    .cap_evt (cap_evt),
    .tmo_evt (tmo_evt)
  );

  rdc_pins #(.CW(CW)) u_pins (
    .st   (st),
    .cyc  (cyc),
    .cfg  (cfg_q),
    .alow (addr_q[1:0]),
    .cs   (mem_cs),
    .oe   (mem_oe),
    .be   (mem_be)
  );

  assign mem_addr  = addr_q;
  assign cpu_ack   = ack_q;
  assign cpu_err   = err_q;
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/rdc_chk.sv
`timescale 1ns/1ps
module rdc_chk #(
  parameter int AW  = 32,
  parameter int CW  = 8,
  parameter int TMO = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          oe,
  input logic          ack,
  input logic          err,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic          in_poll,
  input logic          in_hold,
  input logic [CW-1:0] cyc,
  input logic          tdis,
  input logic          cap_evt,
  input logic          tmo_evt
);

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> cs);  // R3

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);  // R10

  AST_ACK_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || tmo_evt) |=> ack);  // R10

  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ack);  // R7

  AST_HOLD_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> (!cs && !oe));  // R9

  AST_ACK_STROBES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (!cs && !oe));  // R7

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr));  // R11

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_poll && !tdis) |-> (cyc <= CW'(TMO)));  // R7

endmodule

bind membus_rd_ctrl rdc_chk #(.AW(AW), .CW(CW), .TMO(TMO)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs      (mem_cs),
  .oe      (mem_oe),
  .ack     (cpu_ack),
  .err     (cpu_err),
  .addr    (mem_addr),
  .busy    (busy),
  .in_poll (in_poll),
  .in_hold (in_hold),
  .cyc     (cyc),
  .tdis    (tdis_q),
  .cap_evt (cap_evt),
  .tmo_evt (tmo_evt)
);

// File: tb/sim_membus_rd_ctrl.sv
`timescale 1ns/1ps
module sim_membus_rd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [13:0] cpu_cfg = '0;
  logic        cpu_async_rdy = 1'b0;
  logic        cpu_tmo_dis = 1'b0;
  logic        cpu_ack, cpu_err;
  logic [31:0] cpu_rdata;
  logic [31:0] mem_addr;
  logic        mem_cs, mem_oe;
  logic [3:0]  mem_be;
  logic        mem_rdy = 1'b0;
  logic [31:0] mem_din = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  membus_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_cfg(cpu_cfg), .cpu_async_rdy(cpu_async_rdy), .cpu_tmo_dis(cpu_tmo_dis),
    .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_oe(mem_oe), .mem_be(mem_be),
    .mem_rdy(mem_rdy), .mem_din(mem_din)
  );

  function automatic logic [31:0] pat(input int k);
    return {8'(k), 8'(~k), 8'(k * 3), 8'h5A};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one read access, checked every cycle against a timeline derived from the requirements
  task automatic run_txn(input logic [1:0] mode, input bit rdy_en, input int w,
                         input bit csd, input bit oed, input int h, input bit async,
                         input bit tdis, input int r, input logic [31:0] a,
                         input bit keep_req, input string tag);
    logic [13:0] cfgw;
    logic [3:0]  be_exp;
    bit poll, errc;
    int capc, ackc, endc, accl, seen, samp, hc;
    cfgw = {mode, rdy_en, 6'(w), csd, oed, 3'(h)};
    if (mode[1])           be_exp = 4'b1111;
    else if (mode == 2'b01) be_exp = {2'b11, a[1:0]};
    else                    be_exp = {2'b10, a[1:0]};
    poll = rdy_en && (w != 0);
    errc = 1'b0;
    capc = 0;
    if (!poll) capc = 1 + w;
    else begin
      seen = async ? r + 2 : r;
      samp = (seen > 1 + w) ? seen : 1 + w;
      if (!tdis && samp > 128) errc = 1'b1;
      else capc = samp + 1;
    end
    hc = (h == 0) ? 1 : h;
    if (errc) begin accl = 128; ackc = 129; endc = 129; end
    else begin accl = capc; ackc = capc + 1; endc = ackc + hc - 1; end

    @(negedge clk);
    cpu_cfg = cfgw; cpu_addr = a; cpu_async_rdy = async; cpu_tmo_dis = tdis;
    cpu_req = 1'b1; mem_rdy = 1'b0;
    for (int k = 1; k <= endc + 1; k++) begin
      @(negedge clk);
      cpu_req = keep_req && (k <= endc);
      if (keep_req && k == 2) begin
        cpu_addr = ~a; cpu_cfg = ~cfgw; cpu_async_rdy = !async; cpu_tmo_dis = !tdis;
      end
      mem_rdy = (k >= r) && (k <= endc);
      mem_din = pat(k);
      if (k <= endc) begin
        chk("R2", "cs", mem_cs, (k >= 1 + csd && k <= accl));
        chk("R3", "oe", mem_oe, (k >= 1 + csd + oed && k <= accl));
        chk(tag, "ack", cpu_ack, (k == ackc));
        chk("R7", "err", cpu_err, (errc && k == ackc));
        chk("R12", "be", mem_be, be_exp);
        chk(keep_req ? "R11" : "R9", "addr", mem_addr, a);
        if (k == ackc && !errc) chk(tag, "rdata", cpu_rdata, pat(capc));
      end else begin
        chk("R11", "idle cs", mem_cs, 0);
        chk("R10", "idle ack", cpu_ack, 0);
        chk("R12", "idle be", mem_be, 0);
      end
    end
    mem_rdy = 1'b0;
    cpu_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "reset cs", mem_cs, 0);
    chk("R13", "reset oe", mem_oe, 0);
    chk("R13", "reset be", mem_be, 0);
    chk("R13", "reset ack", cpu_ack, 0);
    chk("R13", "reset err", cpu_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // mode rdy w cs oe h async tdis r addr keep tag
    run_txn(2'b10, 1, 0,  0, 0, 0, 0, 0, 1,   32'h0000_1000, 0, "R4");
    run_txn(2'b01, 0, 3,  1, 1, 3, 0, 0, 999, 32'h0000_2002, 0, "R4");
    run_txn(2'b10, 0, 5,  0, 0, 2, 0, 0, 1,   32'h0000_B000, 0, "R4");
    run_txn(2'b11, 1, 1,  0, 1, 1, 0, 0, 1,   32'h0000_3001, 0, "R5");
    run_txn(2'b00, 1, 4,  1, 0, 2, 0, 0, 9,   32'h0000_4003, 0, "R5");
    run_txn(2'b10, 1, 2,  1, 1, 1, 1, 0, 5,   32'h0000_5000, 0, "R6");
    run_txn(2'b10, 1, 2,  0, 0, 0, 1, 0, 1,   32'h0000_6004, 0, "R6");
    run_txn(2'b10, 1, 2,  0, 0, 1, 1, 0, 126, 32'h0000_C000, 0, "R6");
    run_txn(2'b10, 1, 3,  1, 1, 1, 0, 0, 999, 32'h0000_7000, 0, "R7");
    run_txn(2'b10, 1, 2,  0, 1, 2, 0, 0, 128, 32'h0000_8000, 0, "R7");
    run_txn(2'b10, 1, 2,  1, 0, 1, 0, 1, 150, 32'h0000_9000, 0, "R8");
    run_txn(2'b01, 1, 2,  1, 1, 7, 0, 0, 4,   32'h0000_A001, 1, "R1");
    run_txn(2'b00, 1, 63, 1, 1, 4, 0, 0, 1,   32'h0000_D002, 0, "R9");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule